// File: doc/BRIEF.md
# Modem Handshake Flow Controller

This block sits between a UART's serial engines and its modem handshake pins. It handles hardware flow control automatically in both directions. On the receive side it drives an active-low request pin. The pin goes high to pause the remote sender when the local receive FIFO fills past an upper threshold. It goes low again once the FIFO drains to a lower threshold. On the transmit side it watches an active-low clear pin and tells the local transmitter when it may start a character. A pause request never cuts a character short: the halt takes effect only once the character being shifted has finished its stop bit.

A single select bit decides which handshake pair is in use: request-to-send with clear-to-send, or terminal-ready with set-ready. The other pair then acts as plain manually driven or ignored pins. Software configures the block through a small write port. Automatic request control only takes hold once software has manually asserted the selected request pin. A flow-control interrupt flag reports a deassertion of either handshake line. It is guarded by a master enable and two individual enables, and reading the modem status clears it.

Top module: `modem_flow_ctrl`

## Requirements
- R1: After reset, rts_n and dtr_n are high, tx_allow is high and flow_irq is low.
- R2: Register writes use reg_addr 0 for features, 1 for modem control, 2 for interrupt enables, 3 for the upper threshold and 4 for the lower threshold. Each write takes effect at the clock edge that captures it. With automatic request control off, rts_n is the inverse of modem-control bit 1 and dtr_n is the inverse of modem-control bit 0.
- R3: Modem-control bit 2 picks the pair. At 0, rts_n is the automatic request and cts_n is the monitored clear. At 1, dtr_n and dsr_n take those roles. The unselected clear pin has no effect on tx_allow, and the unselected request pin follows only its manual bit.
- R4: Automatic request control is active only while feature bit 6 is set and the manual bit of the selected request pin is 1. Otherwise the request pin ignores the FIFO level.
- R5: While automatic request control is active, the request pin goes high one cycle after rx_level reaches or exceeds the upper threshold. It stays high until rx_level is at or below the lower threshold, and goes low one cycle after that.
- R6: The clear pins pass through a two-stage synchronizer. A change on the selected clear pin first affects tx_allow and flow_irq at the third rising edge after the change.
- R7: With feature bit 7 set, a high clear pin drops tx_allow. While tx_active is high, tx_allow stays high until tx_char_done pulses and drops on the next cycle. With the transmitter idle, it drops at once, after the synchronizer delay.
- R8: When the selected clear pin returns low, tx_allow returns high after the synchronizer delay.
- R9: With feature bit 7 clear, the clear pins never lower tx_allow.
- R10: flow_irq is set when feature bit 4 is 1 and either of two events occurs. One is interrupt-enable bit 7 set together with a low-to-high edge of the synchronized selected clear pin. The other is interrupt-enable bit 6 set together with a low-to-high edge of the selected request pin. With feature bit 4 at 0, neither event sets it.
- R11: A msr_rd pulse clears flow_irq on the next cycle. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| msr_rd | input | 1 | Modem status read strobe, clears flow_irq |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | Stop bit of the current character has completed |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| tx_allow | output | 1 | Transmitter may start a character |
| flow_irq | output | 1 | Flow-control interrupt flag |

## Verification
Three pieces of state can go wrong inside the block: the hysteresis latch, the halt latch and the interrupt flag. A wrong hysteresis latch shows on the request pin one cycle after the FIFO level crosses a threshold, so the bench steps the level through both thresholds from both sides. A wrong halt latch shows on tx_allow either too early, in the middle of a character, or too late, more than three edges after the clear pin moves. The bench checks the exact edge in both directions. A wrong interrupt flag shows within two or three edges of a handshake deassertion, or after a status read that should have cleared it.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
   // register select codes
   localparam logic [2:0] ADDR_FEAT = 3'd0;
   localparam logic [2:0] ADDR_MCTL = 3'd1;
   localparam logic [2:0] ADDR_IEN  = 3'd2;
   localparam logic [2:0] ADDR_HI   = 3'd3;
   localparam logic [2:0] ADDR_LO   = 3'd4;

   // bit positions inside each register
   localparam int FEAT_AUTO_IN  = 7;
   localparam int FEAT_AUTO_OUT = 6;
   localparam int FEAT_IRQ_MST  = 4;
   localparam int MCTL_DTR      = 0;
   localparam int MCTL_RTS      = 1;
   localparam int MCTL_PAIR     = 2;
   localparam int IEN_CLR       = 7;
   localparam int IEN_REQ       = 6;

   typedef struct packed {
      logic auto_in;
      logic auto_out;
      logic irq_master;
      logic pair_dtr;
      logic man_dtr;
      logic man_rts;
      logic ien_clr;
      logic ien_req;
   } mfc_ctrl_t;
endpackage

// File: rtl/mfc_sync.sv
module mfc_sync #(
   parameter int   WIDTH   = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mfc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{{WIDTH{RST_VAL}}}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mfc_rx_throttle.sv
module mfc_rx_throttle #(
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] hi_i,
   input  logic [LVL_W-1:0] lo_i,
   output logic             block_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                block_o <= 1'b0;
      else if (level_i >= hi_i)  block_o <= 1'b1;
      else if (level_i <= lo_i)  block_o <= 1'b0;
   end

   // R5
   hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (block_o && level_i > lo_i) |=> block_o);
   // R5
   hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!block_o && level_i < hi_i) |=> !block_o);
endmodule

// File: rtl/mfc_tx_gate.sv
module mfc_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic clr_hi_i,
   input  logic tx_active_i,
   input  logic char_done_i,
   output logic allow_o
);
   logic halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           halt_q <= 1'b0;
      else if (!enable_i || !clr_hi_i)      halt_q <= 1'b0;
      else if (!tx_active_i || char_done_i) halt_q <= 1'b1;
   end

   assign allow_o = !halt_q;

   // R7
   mid_char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (allow_o && tx_active_i && !char_done_i) |=> allow_o);
   // R8
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_hi_i |=> allow_o);
   // R9
   disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> allow_o);
endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl
   import mfc_pkg::*;
#(
   parameter int LVL_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int HI_DEFAULT  = 12,
   parameter int LO_DEFAULT  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   input  logic             msr_rd,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             tx_active,
   input  logic             tx_char_done,
   input  logic             cts_n,
   input  logic             dsr_n,
   output logic             rts_n,
   output logic             dtr_n,
   output logic             tx_allow,
   output logic             flow_irq
);
   localparam logic [LVL_W-1:0] HI_RST = LVL_W'(HI_DEFAULT);
   localparam logic [LVL_W-1:0] LO_RST = LVL_W'(LO_DEFAULT);

   generate
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_width
         $error("LVL_W must lie in 1..8");
      end
      if (LO_DEFAULT >= HI_DEFAULT) begin : g_bad_thr
         $error("lower threshold default must be below upper");
      end
   endgenerate

   mfc_ctrl_t        ctrl;
   logic [LVL_W-1:0] hi_thr, lo_thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         hi_thr <= HI_RST;
         lo_thr <= LO_RST;
      end else if (reg_we) begin
         case (reg_addr)
            ADDR_FEAT: begin
               ctrl.auto_in    <= reg_wdata[FEAT_AUTO_IN];
               ctrl.auto_out   <= reg_wdata[FEAT_AUTO_OUT];
               ctrl.irq_master <= reg_wdata[FEAT_IRQ_MST];
            end
            ADDR_MCTL: begin
               ctrl.man_dtr  <= reg_wdata[MCTL_DTR];
               ctrl.man_rts  <= reg_wdata[MCTL_RTS];
               ctrl.pair_dtr <= reg_wdata[MCTL_PAIR];
            end
            ADDR_IEN: begin
               ctrl.ien_clr <= reg_wdata[IEN_CLR];
               ctrl.ien_req <= reg_wdata[IEN_REQ];
            end
            ADDR_HI: hi_thr <= reg_wdata[LVL_W-1:0];
            ADDR_LO: lo_thr <= reg_wdata[LVL_W-1:0];
            default: ;
         endcase
      end
   end

   wire unused_wdata = ^reg_wdata;

   // clear inputs: bit 0 = cts, bit 1 = dsr, high means deasserted
   logic [1:0] clr_sync;
   mfc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dsr_n, cts_n}),
      .q_o   (clr_sync)
   );

   logic clr_sel_hi;
   assign clr_sel_hi = ctrl.pair_dtr ? clr_sync[1] : clr_sync[0];

   logic rx_block;
   mfc_rx_throttle #(.LVL_W(LVL_W)) u_throttle (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (rx_level),
      .hi_i    (hi_thr),
      .lo_i    (lo_thr),
      .block_o (rx_block)
   );

   logic rts_hold, dtr_hold;
   assign rts_hold = ctrl.auto_out && ctrl.man_rts && !ctrl.pair_dtr && rx_block;
   assign dtr_hold = ctrl.auto_out && ctrl.man_dtr &&  ctrl.pair_dtr && rx_block;
   assign rts_n    = !(ctrl.man_rts && !rts_hold);
   assign dtr_n    = !(ctrl.man_dtr && !dtr_hold);

   mfc_tx_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (ctrl.auto_in),
      .clr_hi_i    (clr_sel_hi),
      .tx_active_i (tx_active),
      .char_done_i (tx_char_done),
      .allow_o     (tx_allow)
   );

   // deassertion edge detection for both selected lines
   logic req_sel_n, req_prev, clr_prev;
   assign req_sel_n = ctrl.pair_dtr ? dtr_n : rts_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_prev <= 1'b1;
         clr_prev <= 1'b1;
      end else begin
         req_prev <= req_sel_n;
         clr_prev <= clr_sel_hi;
      end
   end

   logic set_evt;
   assign set_evt = ctrl.irq_master &&
                    ((ctrl.ien_clr && clr_sel_hi && !clr_prev) ||
                     (ctrl.ien_req && req_sel_n && !req_prev));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flow_irq <= 1'b0;
      else if (set_evt) flow_irq <= 1'b1;
      else if (msr_rd)  flow_irq <= 1'b0;
   end

   // R10
   no_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.irq_master && !flow_irq) |=> !flow_irq);
   // R11
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && !ctrl.irq_master) |=> !flow_irq);
   // R4
   manual_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.man_rts && !ctrl.man_dtr) |-> (rts_n && dtr_n));
endmodule

// File: tb/modem_flow_ctrl_tb.sv
module modem_flow_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       msr_rd = 1'b0;
   logic [4:0] rx_level = '0;
   logic       tx_active = 1'b0;
   logic       tx_char_done = 1'b0;
   logic       cts_n = 1'b0;
   logic       dsr_n = 1'b0;
   logic       rts_n, dtr_n, tx_allow, flow_irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   modem_flow_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .msr_rd(msr_rd), .rx_level(rx_level),
      .tx_active(tx_active), .tx_char_done(tx_char_done),
      .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n),
      .tx_allow(tx_allow), .flow_irq(flow_irq)
   );

   // {expected rts_n, rx_level}, upper threshold 12, lower threshold 4
   localparam logic [5:0] HYST_TBL [10] = '{
      6'h00, 6'h05, 6'h0B, 6'h2C, 6'h28, 6'h25, 6'h04, 6'h0A, 6'h2F, 6'h03
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 rts_n", rts_n, 1); chk("R1 dtr_n", dtr_n, 1);
      chk("R1 tx_allow", tx_allow, 1); chk("R1 flow_irq", flow_irq, 0);

      // R2 manual drive
      wr(3'd1, 8'h02);
      chk("R2 rts manual", rts_n, 0); chk("R2 dtr manual", dtr_n, 1);
      wr(3'd1, 8'h01);
      chk("R2 rts off", rts_n, 1); chk("R2 dtr on", dtr_n, 0);
      wr(3'd1, 8'h00);
      wr(3'd3, 8'd12);
      wr(3'd4, 8'd4);

      // R4 auto needs manual assert first
      wr(3'd0, 8'h40);
      rx_level = 5'd15; tick(1);
      chk("R4 inactive without manual bit", rts_n, 1);
      rx_level = 5'd0; tick(1);
      wr(3'd1, 8'h02);
      chk("R4 manual start", rts_n, 0);

      // R5 hysteresis table walk
      for (int i = 0; i < 10; i++) begin
         rx_level = HYST_TBL[i][4:0];
         tick(1);
         chk($sformatf("R5 step %0d", i), rts_n, HYST_TBL[i][5]);
      end
      rx_level = 5'd0; tick(1);

      // R3 pair select on request side
      wr(3'd1, 8'h07);
      rx_level = 5'd15; tick(1);
      chk("R3 dtr auto", dtr_n, 1); chk("R3 rts manual only", rts_n, 0);
      rx_level = 5'd0; tick(1);
      chk("R3 dtr reassert", dtr_n, 0);
      wr(3'd1, 8'h02);

      // R9 input auto disabled
      cts_n = 1'b1; tick(4);
      chk("R9 clear ignored", tx_allow, 1);
      cts_n = 1'b0; tick(4);

      // R6 / R7 idle halt, R8 resume
      wr(3'd0, 8'hC0);
      cts_n = 1'b1; tick(2);
      chk("R6 still allowed after two edges", tx_allow, 1);
      tick(1);
      chk("R7 idle halt", tx_allow, 0);
      cts_n = 1'b0; tick(2);
      chk("R8 still halted", tx_allow, 0);
      tick(1);
      chk("R8 resumed", tx_allow, 1);

      // R7 halt at character boundary
      tx_active = 1'b1;
      cts_n = 1'b1; tick(5);
      chk("R7 mid character", tx_allow, 1);
      tx_char_done = 1'b1; tick(1);
      tx_char_done = 1'b0; tx_active = 1'b0;
      chk("R7 after stop bit", tx_allow, 0);
      cts_n = 1'b0; tick(3);
      chk("R8 resume after boundary", tx_allow, 1);

      // R3 pair select on clear side
      wr(3'd1, 8'h05);
      cts_n = 1'b1; tick(4);
      chk("R3 cts ignored", tx_allow, 1);
      cts_n = 1'b0;
      dsr_n = 1'b1; tick(3);
      chk("R3 dsr halts", tx_allow, 0);
      dsr_n = 1'b0; tick(3);
      chk("R3 dsr resume", tx_allow, 1);
      wr(3'd1, 8'h02);

      // R10 master enable gate
      wr(3'd2, 8'h80);
      cts_n = 1'b1; tick(3);
      chk("R10 no master", flow_irq, 0);
      cts_n = 1'b0; tick(3);
      wr(3'd0, 8'hD0);
      cts_n = 1'b1; tick(2);
      chk("R10 before sync", flow_irq, 0);
      tick(1);
      chk("R10 clear edge irq", flow_irq, 1);
      // R11 read clears
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
      chk("R11 read clear", flow_irq, 0);
      cts_n = 1'b0; tick(3);
      chk("R10 falling no irq", flow_irq, 0);

      // R10 request-side irq
      wr(3'd2, 8'h40);
      rx_level = 5'd15; tick(1);
      chk("R10 rts raised", rts_n, 1);
      tick(1);
      chk("R10 request edge irq", flow_irq, 1);
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
      chk("R11 clear request irq", flow_irq, 0);
      rx_level = 5'd0; tick(2);

      // R11 set wins over simultaneous read
      rx_level = 5'd15; tick(1);
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
      chk("R11 set priority", flow_irq, 1);
      msr_rd = 1'b1; tick(1); msr_rd = 1'b0;
      chk("R11 later clear", flow_irq, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule